// File: doc/BRIEF.md
# Bit-Granular Serial Time Slot Router

This block sits between a framed time-division serial link and a small set of serial controller channels. It decides, one bit at a time, which bit positions of the frame carry traffic and which controller each of them belongs to. The ownership rule is held in a route map with one 4-bit entry per bit position. Software-side logic writes the map through a simple write port. Bit-level routing lets a link carry sub-rate channels that are packed a few bits at a time, as in rate adaptation, as well as ordinary 8-bit slots.

A frame sync pulse marks bit position 0. A bit counter then tracks the position on every bit clock. On receive, each enabled bit is handed to its owning controller as a one-cycle strobe with the data bit. Positions that are not enabled produce nothing. On transmit, each enabled position drives the bit that the owning controller presents in that cycle, with a drive enable. All other positions leave the line undriven. When one controller owns several positions, it sees those bits as a single stream in frame order. An entry can also raise an external strobe during its position, so that channels handled outside the chip can be served.

Map writes land in a staging copy. The whole staging copy becomes the working map at the next frame sync, so a frame is never routed with a half-updated map. All outputs are registered and appear one clock after the bit they belong to.

Top module: `bit_slot_router`

## Requirements
- R1: A cycle with `fsync` high is bit position 0. Each cycle after it is the next position, and after position FRAME_BITS-1 the count wraps to 0 even if no sync arrives.
- R2: A map entry is 4 bits wide and is written at address = bit position. Bit 0 enables the position, bits 2:1 select controller 0..3, and bit 3 requests the external strobe.
- R3: For an enabled position, the following cycle shows `ctl_sel` one-hot on the owning controller and `ctl_rx_bit` equal to the `rxd` value of that position. Disabled positions are ignored: `ctl_sel` is all zero and `ctl_rx_bit` is 0.
- R4: For an enabled position, the following cycle shows `txd_en` = 1 and `txd` equal to the owning controller's `ctl_txd` bit from that position. For a disabled position, `txd_en` = 0 and `txd` = 0.
- R5: The cycle after a position, `ext_strobe` equals bit 3 of that position's entry, whether or not bit 0 is set.
- R6: Map writes do not change the map in use until the next `fsync`. The new map applies from bit 0 of the frame that this sync starts.
- R7: Positions routed to the same controller reach that controller as one stream, in frame order, with no bits lost or reordered.
- R8: After reset, every entry of both map copies is 0 and all outputs are 0. Until a map has been written and then activated by a sync, no position is routed.
- R9: A write issued in the same cycle as `fsync` does not affect the frame that starts there. It takes effect at the following sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, high during bit position 0 |
| rxd | input | 1 | Receive serial data |
| map_wr_en | input | 1 | Route map write strobe |
| map_wr_addr | input | $clog2(FRAME_BITS) | Bit position to write |
| map_wr_data | input | 4 | Route entry (see R2) |
| ctl_txd | input | NUM_CTRL | Transmit bit offered by each controller |
| txd | output | 1 | Transmit serial data |
| txd_en | output | 1 | Transmit drive enable, high on routed positions |
| ctl_sel | output | NUM_CTRL | One-hot owner strobe for the last bit |
| ctl_rx_bit | output | 1 | Received bit for the strobed controller |
| ext_strobe | output | 1 | External channel strobe |

## Verification
The bench runs on an 8-bit frame and applies four distinct maps. The first routes every position round-robin across the controllers. The second is sparse, with strobes set on positions where routing is both on and off, which separates the strobe from the enable. The third sends every position to one controller and checks the merged stream. The fourth is empty, so every bit must be ignored. Writes issued mid-frame, and a write issued in the sync cycle itself, show whether the map update is deferred correctly. A long run without sync exercises the counter wrap. Data and transmit bits vary arithmetically from cycle to cycle, so a wrong owner, a wrong bit position or a one-cycle skew each produce a mismatch against the bench's own model.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int ENTRY_W = 4;
  localparam int CTRL_W  = 2;

  typedef struct packed {
    logic              strobe;  // bit 3
    logic [CTRL_W-1:0] ctrl;    // bits 2:1
    logic              en;      // bit 0
  } route_t;
endpackage

// File: rtl/brt_bit_counter.sv
module brt_bit_counter #(
  parameter int FRAME_BITS = 32,
  localparam int IDX_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  output logic [IDX_W-1:0] pos
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

  logic [IDX_W-1:0] cnt_q;

  assign pos = fsync ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= (pos == LAST) ? '0 : pos + 1'b1;
  end

  // R1: the position after the last one is always 0
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (pos == LAST) |=> (pos == '0));
endmodule

// File: rtl/brt_route_map.sv
module brt_route_map
  import brt_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  localparam int IDX_W = $clog2(FRAME_BITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fsync,
  input  logic [IDX_W-1:0]   pos,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  output route_t             entry
);
  logic [FRAME_BITS-1:0][ENTRY_W-1:0] staging_q;
  logic [FRAME_BITS-1:0][ENTRY_W-1:0] active_q;
  logic                               addr_ok;

  assign addr_ok = (32'(wr_addr) < FRAME_BITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      staging_q <= '0;
    end else if (wr_en && addr_ok) begin
      staging_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        active_q <= '0;
    else if (fsync) active_q <= staging_q;
  end

  // Bit 0 of a new frame reads the staging copy directly, so the map
  // being activated in this cycle already governs it.
  assign entry = route_t'(fsync ? staging_q[0] : active_q[pos]);

  // R6: the working map only changes on a sync cycle
  a_r6_map_frozen: assert property (@(posedge clk) disable iff (rst)
    !fsync |=> $stable(active_q));
endmodule

// File: rtl/brt_lane_io.sv
module brt_lane_io
  import brt_pkg::*;
#(
  parameter int NUM_CTRL = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  route_t              entry,
  input  logic                rxd,
  input  logic [NUM_CTRL-1:0] ctl_txd,
  output logic                txd,
  output logic                txd_en,
  output logic [NUM_CTRL-1:0] ctl_sel,
  output logic                ctl_rx_bit,
  output logic                ext_strobe
);
  logic                hit;
  logic [NUM_CTRL-1:0] sel_d;
  logic [NUM_CTRL-1:0] tx_pick;

  assign hit = entry.en && (32'(entry.ctrl) < NUM_CTRL);

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_lane
    assign sel_d[k]   = hit && (entry.ctrl == CTRL_W'(k));
    assign tx_pick[k] = sel_d[k] && ctl_txd[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd        <= 1'b0;
      txd_en     <= 1'b0;
      ctl_sel    <= '0;
      ctl_rx_bit <= 1'b0;
      ext_strobe <= 1'b0;
    end else begin
      txd        <= |tx_pick;
      txd_en     <= hit;
      ctl_sel    <= sel_d;
      ctl_rx_bit <= hit && rxd;
      ext_strobe <= entry.strobe;
    end
  end

  // R3: at most one controller owns a bit
  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl_sel));
  // R4: drive enable and owner strobe describe the same position
  a_r4_en_tracks_sel: assert property (@(posedge clk) disable iff (rst)
    txd_en == (ctl_sel != '0));
  // R4: unrouted positions leave data outputs low
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !txd_en |-> (!txd && !ctl_rx_bit));
endmodule

// File: rtl/bit_slot_router.sv
module bit_slot_router
  import brt_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int NUM_CTRL   = 4,
  localparam int IDX_W = $clog2(FRAME_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fsync,
  input  logic                rxd,
  input  logic                map_wr_en,
  input  logic [IDX_W-1:0]    map_wr_addr,
  input  logic [ENTRY_W-1:0]  map_wr_data,
  input  logic [NUM_CTRL-1:0] ctl_txd,
  output logic                txd,
  output logic                txd_en,
  output logic [NUM_CTRL-1:0] ctl_sel,
  output logic                ctl_rx_bit,
  output logic                ext_strobe
);
  logic [IDX_W-1:0] pos;
  route_t           entry;

  brt_bit_counter #(.FRAME_BITS(FRAME_BITS)) u_counter (
    .clk(clk), .rst(rst), .fsync(fsync), .pos(pos)
  );

  brt_route_map #(.FRAME_BITS(FRAME_BITS)) u_map (
    .clk(clk), .rst(rst), .fsync(fsync), .pos(pos),
    .wr_en(map_wr_en), .wr_addr(map_wr_addr), .wr_data(map_wr_data),
    .entry(entry)
  );

  brt_lane_io #(.NUM_CTRL(NUM_CTRL)) u_lanes (
    .clk(clk), .rst(rst), .entry(entry), .rxd(rxd), .ctl_txd(ctl_txd),
    .txd(txd), .txd_en(txd_en), .ctl_sel(ctl_sel),
    .ctl_rx_bit(ctl_rx_bit), .ext_strobe(ext_strobe)
  );

  // R8: a cycle in reset leaves every output low at the next edge
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!txd_en && !txd && ctl_sel == '0 && !ext_strobe && !ctl_rx_bit));
endmodule

// File: tb/test_bit_slot_router.sv
module test_bit_slot_router;
  localparam int F  = 8;
  localparam int NC = 4;
  localparam int IW = $clog2(F);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fsync = 1'b0;
  logic          rxd = 1'b0;
  logic          map_wr_en = 1'b0;
  logic [IW-1:0] map_wr_addr = '0;
  logic [3:0]    map_wr_data = '0;
  logic [NC-1:0] ctl_txd = '0;
  logic          txd, txd_en, ctl_rx_bit, ext_strobe;
  logic [NC-1:0] ctl_sel;

  bit_slot_router #(.FRAME_BITS(F), .NUM_CTRL(NC)) i_bit_slot_router (
    .clk(clk), .rst(rst), .fsync(fsync), .rxd(rxd),
    .map_wr_en(map_wr_en), .map_wr_addr(map_wr_addr), .map_wr_data(map_wr_data),
    .ctl_txd(ctl_txd), .txd(txd), .txd_en(txd_en), .ctl_sel(ctl_sel),
    .ctl_rx_bit(ctl_rx_bit), .ext_strobe(ext_strobe)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int gcyc = 0;
  bit done = 1'b0;

  logic [3:0] mstage [F];
  logic [3:0] mact   [F];
  int mcnt = 0;

  int exp_q [64];
  int got_q [64];
  int exp_n = 0;
  int got_n = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, gcyc);
    end
  endtask

  task automatic step(input bit fs, input bit we, input int wa,
                      input logic [3:0] wd, input string tag);
    logic [3:0] e;
    int p;
    logic rx;
    logic [NC-1:0] tx;
    int exp_sel, exp_tx, exp_rx;
    @(negedge clk);
    rx = 1'(((gcyc * 13) >> 2) ^ gcyc);
    tx = NC'((gcyc * 7) + (gcyc >> 3));
    fsync = fs; rxd = rx; ctl_txd = tx;
    map_wr_en = we; map_wr_addr = IW'(wa); map_wr_data = wd;
    p = fs ? 0 : mcnt;
    e = fs ? mstage[0] : mact[p];
    exp_sel = e[0] ? (1 << e[2:1]) : 0;
    exp_tx  = e[0] ? int'(tx[e[2:1]]) : 0;
    exp_rx  = e[0] ? int'(rx) : 0;
    @(posedge clk);
    #1;
    chk({tag, "/R3 sel"}, int'(ctl_sel), exp_sel);
    chk({tag, "/R3 rxbit"}, int'(ctl_rx_bit), exp_rx);
    chk({tag, "/R4 txen"}, int'(txd_en), int'(e[0]));
    chk({tag, "/R4 txd"}, int'(txd), exp_tx);
    chk({tag, "/R5 strobe"}, int'(ext_strobe), int'(e[3]));
    if (exp_sel[2] && exp_n < 64) begin exp_q[exp_n] = exp_rx; exp_n++; end
    if (ctl_sel[2] && got_n < 64) begin got_q[got_n] = int'(ctl_rx_bit); got_n++; end
    if (fs) for (int i = 0; i < F; i++) mact[i] = mstage[i];
    if (we && wa < F) mstage[wa] = wd;
    mcnt = (p == F - 1) ? 0 : p + 1;
    gcyc++;
  endtask

  task automatic run(input int n, input int period, input string tag);
    for (int i = 0; i < n; i++)
      step(period != 0 && (i % period) == 0, 1'b0, 0, 4'h0, tag);
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < F; i++) begin mstage[i] = '0; mact[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R8: outputs are low while in reset
    chk("R8 reset txen", int'(txd_en), 0);
    chk("R8 reset sel", int'(ctl_sel), 0);
    chk("R8 reset strobe", int'(ext_strobe), 0);
    @(negedge clk);
    rst = 1'b0;
    // R8: no routing before any map is written and synced
    run(10, 0, "R8");
    run(8, 8, "R8");

    // R2: round-robin map, all positions enabled; staged only (R6)
    for (int a = 0; a < F; a++)
      step(1'b0, 1'b1, a, {1'b0, 2'(a % 4), 1'b1}, "R6");
    run(24, 8, "R2");

    // R5: sparse map with strobes, written mid-frame (R6)
    step(1'b1, 1'b0, 0, 4'h0, "R6");
    step(1'b0, 1'b0, 0, 4'h0, "R6");
    for (int a = 0; a < F; a++)
      step(1'b0, 1'b1, a, {1'(a % 3 == 0), 2'((a * 3) % 4), 1'(a % 2)}, "R6");
    run(16, 8, "R5");

    // R7: every position to controller 2, merged stream in order
    for (int a = 0; a < F; a++)
      step(1'b0, 1'b1, a, {1'(a % 2 == 0), 2'd2, 1'b1}, "R6");
    exp_n = 0; got_n = 0;
    run(16, 8, "R7");
    chk("R7 merged count", got_n, exp_n);
    chk("R7 merged count full", got_n, 16);
    for (int i = 0; i < 16; i++) chk("R7 merged order", got_q[i], exp_q[i]);

    // R9: write in the sync cycle applies only from the next sync
    step(1'b1, 1'b1, 0, 4'b0001, "R9");
    run(7, 0, "R9");
    run(16, 8, "R9");

    // R1: no sync for several frames, position counter wraps
    run(20, 0, "R1");

    // R3: empty map, every received bit is ignored
    for (int a = 0; a < F; a++) step(1'b0, 1'b1, a, 4'h0, "R3");
    run(16, 8, "R3");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule